// File: doc/BRIEF.md
# Mode-Configurable External Chip-Select Decoder

This block produces three active-low chip-enable pins for external memory from a 24-bit CPU address. Where each enable lands depends on a bus-mode strap, on a strap that says whether on-chip ROM is present, and on a window-size field written by software. An enable is driven only for an access that goes off chip. An access that hits internal memory drives none, and while the CPU is in standby every enable is held high.

The straps are captured on the first clock after reset and stay fixed from then on. In single-chip mode no enable is produced. The three pins then carry the contents of a software-written port data register. Enables are registered on the access strobe, so each pin settles one clock after the address is presented. The windows never overlap, so at most one pin is low at a time.

Top module: `cs_decoder_top`

## Requirements
- R1: During and after reset, before any write, `ce_n_o` is 3'b111, `size_o` is 0 (the 8 KB setting) and `port_o` is 3'b111.
- R2: When the captured bus mode is single-chip (`bus_mode_i`=0), `ce_n_o` equals `port_o`. A port write shows on the pins on the clock after the write.
- R3: In expanded-64K mode (`bus_mode_i`=1) with `rom_present_i`=1, the enables use these windows. With `size_o`=0 (8 KB), pin 0 covers 0x8000–0x9FFF, pin 1 covers 0xA000–0xBFFF and pin 2 covers 0xC000–0xDFFF. With `size_o`=1 (16 KB), pin 0 covers 0x7000–0xAFFF and pin 1 covers 0xB000–0xEFFF. With `size_o`=2 (32 KB), pin 0 covers 0x8000–0xEFFF.
- R4: In expanded-64K mode with `rom_present_i`=0, the enables use these windows. With `size_o`=0, the three pins cover 0x0000–0x1FFF, 0x2000–0x3FFF and 0x4000–0x5FFF. With `size_o`=1, they cover 0x0000–0x3FFF, 0x4000–0x7FFF and 0x8000–0xBFFF. With `size_o`=2, pin 0 covers 0x0000–0x7FFF and pin 1 covers 0x8000–0xEFFF. With `size_o`=3 (64 KB), pin 0 covers 0x0000–0xEFFF.
- R5: In either expanded-4M mode (`bus_mode_i`=2 or 3), the window size is ignored. Pin 1 covers 0x400000–0x7FFFFF and pin 2 covers 0x800000–0xBFFFFF. Pin 0 covers 0xC00000–0xFFFFFF when ROM is present. Without ROM, pin 0 covers both 0x000000–0x00EFFF and 0x010000–0x3FFFFF.
- R6: In expanded modes, a pin goes low on the clock after a cycle that has `ext_acc_i`=1 and an address inside that pin's window. A cycle with `ext_acc_i`=0, or with an address outside every window, gives 3'b111 on the next clock. At most one pin is low at any time.
- R7: An access with `int_hit_i`=1 drives no enable, even when its address lies inside a window.
- R8: While `standby_i`=1 in an expanded mode, `ce_n_o` is 3'b111 in that same cycle, whatever the address.
- R9: In expanded-64K mode with ROM present, `size_o`=3 is undefined, and no enable is driven for any address.
- R10: The bus-mode and ROM straps are captured on the first clock after reset. Later changes on `bus_mode_i` and `rom_present_i` have no effect until the next reset.
- R11: A write with `wr_sel_i`=0 loads `wr_data_i[1:0]` into the size field. A write with `wr_sel_i`=1 loads `wr_data_i[2:0]` into the port register. `size_o` and `port_o` read back the written values in every mode.
- R12: In expanded-64K mode only `addr_i[15:0]` is decoded, and `addr_i[23:16]` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 24 | CPU address |
| ext_acc_i | input | 1 | Access strobe for this cycle |
| int_hit_i | input | 1 | The address hits internal memory |
| standby_i | input | 1 | The CPU is in a halt or sleep state |
| bus_mode_i | input | 2 | Bus mode strap: 0 single-chip, 1 expanded 64K, 2 and 3 expanded 4M |
| rom_present_i | input | 1 | Strap: on-chip ROM present |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 size field, 1 port register |
| wr_data_i | input | 3 | Write data |
| ce_n_o | output | 3 | Chip-enable pins, active low, or port bits in single-chip mode |
| size_o | output | 2 | Size field readback |
| port_o | output | 3 | Port register readback |

## Verification
Each of the eight strap combinations is run through all four window sizes. The addresses are drawn from window edges and the values one past them, from those same edges with random upper bits, and from fully random values. The edge values separate off-by-one and overlapping windows. The random upper bits separate a 16-bit decode from a 24-bit one, and the random addresses catch stray hits outside the windows. Random internal hits, standby and idle strobes check that each gating term suppresses an enable that would otherwise be driven. A change of strap after reset and port writes in single-chip mode show that the captured straps stay fixed and that the pins carry the port data.

// File: rtl/cs_pkg.sv
package cs_pkg;
  parameter int unsigned ADDR_W = 24;
  parameter int unsigned NUM_CE = 3;
  parameter int unsigned SIZE_W = 2;
  parameter int unsigned MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    BM_SINGLE    = 2'd0,
    BM_EXP64     = 2'd1,
    BM_EXP4M_MIN = 2'd2,
    BM_EXP4M_MAX = 2'd3
  } bus_mode_e;

  typedef enum logic [SIZE_W-1:0] {
    WS_8K  = 2'd0,
    WS_16K = 2'd1,
    WS_32K = 2'd2,
    WS_64K = 2'd3
  } win_size_e;

  typedef struct packed {
    logic              en;
    logic [ADDR_W-1:0] lo;
    logic [ADDR_W-1:0] hi;
  } span_t;

  typedef struct packed {
    span_t a;
    span_t b;
  } win_t;

  function automatic span_t mk_span(logic [ADDR_W-1:0] lo, logic [ADDR_W-1:0] hi);
    span_t s;
    s.en = 1'b1;
    s.lo = lo;
    s.hi = hi;
    return s;
  endfunction

  // Windows per channel; an undefined setting leaves both spans disabled
  function automatic win_t win_of(bus_mode_e mode, logic rom, win_size_e size, int ch);
    win_t w;
    w = '0;
    unique case (mode)
      BM_EXP64: begin
        if (rom) begin
          unique case (size)
            WS_8K:  w.a = mk_span(24'h008000 + 24'(ch) * 24'h2000,
                                  24'h009FFF + 24'(ch) * 24'h2000);
            WS_16K: if (ch < 2) w.a = mk_span(24'h007000 + 24'(ch) * 24'h4000,
                                              24'h00AFFF + 24'(ch) * 24'h4000);
            WS_32K: if (ch == 0) w.a = mk_span(24'h008000, 24'h00EFFF);
            default: w = '0;
          endcase
        end else begin
          unique case (size)
            WS_8K:  w.a = mk_span(24'(ch) * 24'h2000, 24'h001FFF + 24'(ch) * 24'h2000);
            WS_16K: w.a = mk_span(24'(ch) * 24'h4000, 24'h003FFF + 24'(ch) * 24'h4000);
            WS_32K: begin
              if (ch == 0) w.a = mk_span(24'h000000, 24'h007FFF);
              else if (ch == 1) w.a = mk_span(24'h008000, 24'h00EFFF);
            end
            WS_64K: if (ch == 0) w.a = mk_span(24'h000000, 24'h00EFFF);
            default: w = '0;
          endcase
        end
      end
      BM_EXP4M_MIN, BM_EXP4M_MAX: begin
        if (ch == 0) begin
          if (rom) begin
            w.a = mk_span(24'hC00000, 24'hFFFFFF);
          end else begin
            w.a = mk_span(24'h000000, 24'h00EFFF);
            w.b = mk_span(24'h010000, 24'h3FFFFF);
          end
        end else begin
          w.a = mk_span(24'(ch) * 24'h400000, 24'h3FFFFF + 24'(ch) * 24'h400000);
        end
      end
      default: w = '0;
    endcase
    return w;
  endfunction
endpackage

// File: rtl/cs_strap_latch.sv
module cs_strap_latch
  import cs_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic [MODE_W-1:0] mode_i,
  input  logic      rom_i,
  output bus_mode_e mode_o,
  output logic      rom_o,
  output logic      done_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o <= BM_SINGLE;
      rom_o  <= 1'b0;
      done_o <= 1'b0;
    end else if (!done_o) begin
      mode_o <= bus_mode_e'(mode_i);
      rom_o  <= rom_i;
      done_o <= 1'b1;
    end
  end
endmodule

// File: rtl/cs_cfg_regs.sv
module cs_cfg_regs
  import cs_pkg::*;
#(
  parameter int unsigned PORT_W = NUM_CE
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [PORT_W-1:0] wr_data_i,
  output win_size_e         size_o,
  output logic [PORT_W-1:0] port_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      size_o <= WS_8K;
      port_o <= '1;
    end else if (wr_en_i) begin
      if (wr_sel_i) port_o <= wr_data_i;
      else          size_o <= win_size_e'(wr_data_i[SIZE_W-1:0]);
    end
  end
endmodule

// File: rtl/cs_window_decode.sv
module cs_window_decode
  import cs_pkg::*;
(
  input  bus_mode_e         mode_i,
  input  logic              rom_i,
  input  win_size_e         size_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [NUM_CE-1:0] hit_o
);
  localparam int unsigned NARROW_W = 16;

  logic [ADDR_W-1:0] eff_addr;

  // 64K modes see only the low address bits
  assign eff_addr = (mode_i == BM_EXP64)
                  ? {{(ADDR_W-NARROW_W){1'b0}}, addr_i[NARROW_W-1:0]}
                  : addr_i;

  for (genvar g = 0; g < NUM_CE; g++) begin : g_ch
    win_t w;
    always_comb w = win_of(mode_i, rom_i, size_i, g);
    assign hit_o[g] = (w.a.en && eff_addr >= w.a.lo && eff_addr <= w.a.hi)
                   || (w.b.en && eff_addr >= w.b.lo && eff_addr <= w.b.hi);
  end
endmodule

// File: rtl/cs_decoder_top.sv
module cs_decoder_top
  import cs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ext_acc_i,
  input  logic              int_hit_i,
  input  logic              standby_i,
  input  logic [MODE_W-1:0] bus_mode_i,
  input  logic              rom_present_i,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [NUM_CE-1:0] wr_data_i,
  output logic [NUM_CE-1:0] ce_n_o,
  output logic [SIZE_W-1:0] size_o,
  output logic [NUM_CE-1:0] port_o
);
  bus_mode_e         mode_q;
  logic              rom_q;
  logic              strap_done;
  win_size_e         size_q;
  logic [NUM_CE-1:0] port_q;
  logic [NUM_CE-1:0] hit;
  logic [NUM_CE-1:0] ce_n_q;
  logic              fire;

  cs_strap_latch u_strap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mode_i (bus_mode_i),
    .rom_i  (rom_present_i),
    .mode_o (mode_q),
    .rom_o  (rom_q),
    .done_o (strap_done)
  );

  cs_cfg_regs #(.PORT_W(NUM_CE)) u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .size_o    (size_q),
    .port_o    (port_q)
  );

  cs_window_decode u_dec (
    .mode_i (mode_q),
    .rom_i  (rom_q),
    .size_i (size_q),
    .addr_i (addr_i),
    .hit_o  (hit)
  );

  assign fire = strap_done && ext_acc_i && !int_hit_i && !standby_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ce_n_q <= '1;
    else if (fire) ce_n_q <= ~hit;
    else           ce_n_q <= '1;
  end

  assign ce_n_o = (mode_q == BM_SINGLE) ? port_q
                : (standby_i ? {NUM_CE{1'b1}} : ce_n_q);
  assign size_o = size_q;
  assign port_o = port_q;
endmodule

// File: rtl/cs_decoder_chk.sv
module cs_decoder_chk
  import cs_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NUM_CE-1:0] ce_n_o,
  input logic              ext_acc_i,
  input logic              int_hit_i,
  input logic              standby_i,
  input bus_mode_e         mode_q,
  input logic              rom_q,
  input win_size_e         size_q,
  input logic [NUM_CE-1:0] port_q,
  input logic              strap_done
);
  logic expanded;
  assign expanded = (mode_q != BM_SINGLE);

  assert_single_port_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == BM_SINGLE) |-> (ce_n_o == port_q));

  assert_onehot_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expanded |-> $onehot0(~ce_n_o));

  assert_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expanded && !ext_acc_i) |=> (&ce_n_o));

  assert_int_hit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expanded && int_hit_i) |=> (&ce_n_o));

  assert_standby_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expanded && standby_i) |-> (&ce_n_o));

  assert_undef_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == BM_EXP64 && rom_q && size_q == WS_64K) |=> (&ce_n_o));

  assert_strap_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strap_done |=> ($stable(mode_q) && $stable(rom_q) && strap_done));
endmodule

bind cs_decoder_top cs_decoder_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ce_n_o     (ce_n_o),
  .ext_acc_i  (ext_acc_i),
  .int_hit_i  (int_hit_i),
  .standby_i  (standby_i),
  .mode_q     (mode_q),
  .rom_q      (rom_q),
  .size_q     (size_q),
  .port_q     (port_q),
  .strap_done (strap_done)
);

// File: tb/tb_cs_decoder_top.sv
`timescale 1ns/1ps
module tb_cs_decoder_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [23:0] addr = '0;
  logic        ext_acc = 1'b0, int_hit = 1'b0, standby = 1'b0;
  logic [1:0]  bus_mode = 2'd0;
  logic        rom = 1'b0;
  logic        wr_en = 1'b0, wr_sel = 1'b0;
  logic [2:0]  wr_data = '0;
  logic [2:0]  ce_n;
  logic [1:0]  size_rb;
  logic [2:0]  port_rb;

  int checks = 0;
  int errors = 0;
  int cur_mode = 0;
  bit cur_rom = 1'b0;
  int cur_size = 0;
  logic [2:0] cur_port = 3'b111;

  always #5 clk = ~clk;

  cs_decoder_top dut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .ext_acc_i(ext_acc),
    .int_hit_i(int_hit), .standby_i(standby), .bus_mode_i(bus_mode),
    .rom_present_i(rom), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .ce_n_o(ce_n), .size_o(size_rb), .port_o(port_rb)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit in_r(logic [23:0] a, logic [23:0] lo, logic [23:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

  // Active-high hit vector {pin2,pin1,pin0} from the window tables
  function automatic logic [2:0] ref_hit(int mode, bit r, int sz, logic [23:0] a);
    logic [23:0] s;
    logic [2:0] h;
    s = {8'h00, a[15:0]};
    h = 3'b000;
    if (mode == 1 && r) begin
      case (sz)
        0: h = {in_r(s,24'hC000,24'hDFFF), in_r(s,24'hA000,24'hBFFF), in_r(s,24'h8000,24'h9FFF)};
        1: h = {1'b0, in_r(s,24'hB000,24'hEFFF), in_r(s,24'h7000,24'hAFFF)};
        2: h = {2'b00, in_r(s,24'h8000,24'hEFFF)};
        default: h = 3'b000;
      endcase
    end else if (mode == 1) begin
      case (sz)
        0: h = {in_r(s,24'h4000,24'h5FFF), in_r(s,24'h2000,24'h3FFF), in_r(s,24'h0000,24'h1FFF)};
        1: h = {in_r(s,24'h8000,24'hBFFF), in_r(s,24'h4000,24'h7FFF), in_r(s,24'h0000,24'h3FFF)};
        2: h = {1'b0, in_r(s,24'h8000,24'hEFFF), in_r(s,24'h0000,24'h7FFF)};
        default: h = {2'b00, in_r(s,24'h0000,24'hEFFF)};
      endcase
    end else if (mode >= 2) begin
      h[2] = in_r(a,24'h800000,24'hBFFFFF);
      h[1] = in_r(a,24'h400000,24'h7FFFFF);
      h[0] = r ? in_r(a,24'hC00000,24'hFFFFFF)
               : (in_r(a,24'h000000,24'h00EFFF) || in_r(a,24'h010000,24'h3FFFFF));
    end
    return h;
  endfunction

  function automatic string tag_of(bit ext, bit hit, bit sb);
    if (cur_mode == 0) return "R2";
    if (sb) return "R8";
    if (hit) return "R7";
    if (!ext) return "R6";
    if (cur_mode >= 2) return "R5";
    if (cur_rom && cur_size == 3) return "R9";
    return cur_rom ? "R3" : "R4";
  endfunction

  task automatic do_reset(int mode, bit r);
    @(negedge clk);
    rst_ni = 1'b0; bus_mode = 2'(mode); rom = r;
    ext_acc = 0; int_hit = 0; standby = 0; wr_en = 0;
    #3;
    chk("R1 ce", {5'd0, ce_n}, 8'h07);
    chk("R1 size", {6'd0, size_rb}, 8'h00);
    chk("R1 port", {5'd0, port_rb}, 8'h07);
    @(negedge clk); rst_ni = 1'b1;
    @(negedge clk);
    cur_mode = mode; cur_rom = r; cur_size = 0; cur_port = 3'b111;
  endtask

  task automatic wr(bit sel, logic [2:0] d);
    @(negedge clk);
    wr_en = 1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 0;
    if (sel) begin
      cur_port = d;
      chk("R11 port", {5'd0, port_rb}, {5'd0, d});
    end else begin
      cur_size = int'(d[1:0]);
      chk("R11 size", {6'd0, size_rb}, {6'd0, d[1:0]});
    end
  endtask

  task automatic access(logic [23:0] a, bit ext, bit hit, bit sb, string tag);
    logic [2:0] exp;
    @(negedge clk);
    addr = a; ext_acc = ext; int_hit = hit; standby = sb;
    @(negedge clk);
    if (cur_mode == 0) exp = cur_port;
    else if (sb || hit || !ext) exp = 3'b111;
    else exp = ~ref_hit(cur_mode, cur_rom, cur_size, a);
    chk(tag, {5'd0, ce_n}, {5'd0, exp});
  endtask

  function automatic logic [23:0] pick_addr();
    logic [15:0] e16 [21] = '{16'h0000,16'h1FFF,16'h2000,16'h3FFF,16'h4000,16'h5FFF,
      16'h6FFF,16'h7000,16'h7FFF,16'h8000,16'h9FFF,16'hA000,16'hAFFF,16'hB000,
      16'hBFFF,16'hC000,16'hDFFF,16'hE000,16'hEFFF,16'hF000,16'hFFFF};
    logic [23:0] e24 [12] = '{24'h000000,24'h00EFFF,24'h00F000,24'h00FFFF,24'h010000,
      24'h3FFFFF,24'h400000,24'h7FFFFF,24'h800000,24'hBFFFFF,24'hC00000,24'hFFFFFF};
    int k;
    k = int'($urandom % 4);
    if (k == 0) return {8'($urandom), e16[$urandom % 21]};
    if (k == 1) return e24[$urandom % 12];
    return 24'($urandom);
  endfunction

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));

    // Single-chip: pins follow the port register
    do_reset(0, 1'b0);
    wr(1'b1, 3'b010);
    chk("R2 pins", {5'd0, ce_n}, 8'h02);
    access(24'h008000, 1, 0, 0, "R2 access");
    wr(1'b0, 3'b010);
    wr(1'b1, 3'b101);
    chk("R2 pins2", {5'd0, ce_n}, 8'h05);

    // Strap change after reset is ignored
    do_reset(1, 1'b0);
    bus_mode = 2'd0; rom = 1'b1;
    access(24'h001000, 1, 0, 0, "R10 strap");
    chk("R10 pin0", {5'd0, ce_n}, 8'h06);
    access(24'hAB2000, 1, 0, 0, "R12 upper");
    chk("R12 pin1", {5'd0, ce_n}, 8'h05);

    // Undefined size with ROM
    do_reset(1, 1'b1);
    wr(1'b0, 3'd3);
    access(24'h008000, 1, 0, 0, "R9 undef");
    access(24'h00C000, 1, 0, 0, "R9 undef2");
    access(24'h009000, 1, 0, 1, "R8 standby");
    access(24'h400000, 1, 1, 0, "R7 int");

    for (int m = 0; m < 4; m++) begin
      for (int r = 0; r < 2; r++) begin
        do_reset(m, r[0]);
        for (int sz = 0; sz < 4; sz++) begin
          wr(1'b0, 3'(sz));
          if (m == 0) wr(1'b1, 3'($urandom));
          for (int i = 0; i < 60; i++) begin
            logic [23:0] a;
            bit e, h, s;
            a = pick_addr();
            e = ($urandom % 8) != 0;
            h = ($urandom % 10) == 0;
            s = ($urandom % 12) == 0;
            access(a, e, h, s, tag_of(e, h, s));
          end
        end
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule